// File: doc/BRIEF.md
# Cumulative Row Boundary Decoder

This block tells a memory controller which of its DRAM chip-select rows owns a physical address. Software programs one 8-bit limit per row through a small write port. Each limit counts in 16 MB units and marks the top of its row. The rows are stacked one after another: a row begins where the row below it ended, and row 0 begins at address zero.

The lookup is purely combinational from the programmed limits. For the address on `addr_i` the block returns a one-hot row select, a hit flag, and the byte offset of the address inside its row. A row can be made empty by giving it a limit that does not rise above the top of the rows below it. This makes it possible to describe sparse populations, and rows of different sizes can be mixed freely.

Top module: `rowbound_decoder`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` as the limit of row `wr_idx_i` (0 to 3) at the rising clock edge. The lookup uses the new limit from that edge onward and uses the old limit before it.
- R2: After reset every limit is 0, so every address returns `hit_o` = 0 and `row_sel_o` = 0.
- R3: Limits are in 16 MB units. Row n owns the addresses whose bits [31:24] satisfy base_n <= addr[31:24] < limit_n.
- R4: The base of row 0 is 0. The base of row n is the largest limit programmed in rows 0 to n-1.
- R5: A row whose limit is less than or equal to its base is empty and is never selected. This covers equal limits and limits written out of order, and no range wraps around.
- R6: Bit n of `row_sel_o` selects row n, and at most one bit is set. If several rows could claim an address, the lowest-numbered row wins.
- R7: An address at or above the highest programmed limit gives `hit_o` = 0 and `row_sel_o` = 0.
- R8: On a hit, `row_off_o` equals the address minus (base of the selected row × 16 MB). On a miss, `row_off_o` is 0.
- R9: Row sizes from one unit (16 MB) up to 32 units (512 MB) and beyond may sit next to each other, and each decodes with its own size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all limits |
| wr_en_i | input | 1 | Write strobe for a limit register |
| wr_idx_i | input | 2 | Row whose limit is written |
| wr_data_i | input | 8 | New limit in 16 MB units |
| addr_i | input | 32 | Physical address to decode |
| row_sel_o | output | 4 | One-hot selected row |
| hit_o | output | 1 | Address falls inside some row |
| row_off_o | output | 32 | Byte offset within the selected row |

## Verification
The assertions assume that reset is held low from time zero until the first edges have passed. They also assume that `addr_i` and the write inputs change only away from the rising edge, so the combinational outputs are stable when they are sampled. The bench drives every input on the falling edge and holds reset for several cycles. It rewrites all four limits at the start of each scenario, so no result depends on values left over from an earlier one. Each scenario decodes addresses on both sides of every boundary, including the empty and out-of-order cases.

// File: rtl/rowbound_pkg.sv
package rowbound_pkg;
    localparam int DEF_ROWS       = 4;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_UNIT_SHIFT = 24;
endpackage

// File: rtl/rowbound_regs.sv
module rowbound_regs #(
    parameter int ROWS  = 4,
    parameter int LW    = 8,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [LW-1:0]        wr_data_i,
    output logic [ROWS*LW-1:0]   lim_o
);
    typedef struct packed {
        logic [ROWS-1:0][LW-1:0] lim;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            for (int r = 0; r < ROWS; r++) begin
                if (wr_idx_i == IDX_W'(r)) st_d.lim[r] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lim_o = st_q.lim;
endmodule

// File: rtl/rowbound_chain.sv
module rowbound_chain #(
    parameter int ROWS = 4,
    parameter int LW   = 8
) (
    input  logic [ROWS*LW-1:0] lim_i,
    output logic [ROWS*LW-1:0] base_o,
    output logic [ROWS-1:0]    live_o
);
    logic [LW-1:0] run_s [ROWS+1];

    assign run_s[0] = '0;

    generate
        for (genvar g = 0; g < ROWS; g++) begin : g_stage
            logic [LW-1:0] own_s;
            assign own_s                 = lim_i[g*LW +: LW];
            assign base_o[g*LW +: LW]    = run_s[g];
            assign live_o[g]             = own_s > run_s[g];
            assign run_s[g+1]            = live_o[g] ? own_s : run_s[g];
        end
    endgenerate
endmodule

// File: rtl/rowbound_match.sv
module rowbound_match #(
    parameter int ROWS       = 4,
    parameter int LW         = 8,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 24
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [ROWS*LW-1:0] lim_i,
    input  logic [ROWS*LW-1:0] base_i,
    input  logic [ROWS-1:0]    live_i,
    output logic [ROWS-1:0]    sel_o,
    output logic               hit_o,
    output logic [ADDR_W-1:0]  off_o
);
    logic [LW-1:0]   hi_s;
    logic [ROWS-1:0] cand_s;
    logic [LW-1:0]   sel_base_s;

    assign hi_s = addr_i[ADDR_W-1:UNIT_SHIFT];

    generate
        for (genvar g = 0; g < ROWS; g++) begin : g_cand
            assign cand_s[g] = live_i[g]
                             && (hi_s >= base_i[g*LW +: LW])
                             && (hi_s <  lim_i[g*LW +: LW]);
        end
    endgenerate

    always_comb begin
        sel_o      = '0;
        hit_o      = 1'b0;
        sel_base_s = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (cand_s[r] && !hit_o) begin
                sel_o[r]   = 1'b1;
                hit_o      = 1'b1;
                sel_base_s = base_i[r*LW +: LW];
            end
        end
    end

    assign off_o = hit_o ? {hi_s - sel_base_s, addr_i[UNIT_SHIFT-1:0]} : '0;
endmodule

// File: rtl/rowbound_decoder.sv
module rowbound_decoder
    import rowbound_pkg::*;
#(
    parameter int ROWS       = DEF_ROWS,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int UNIT_SHIFT = DEF_UNIT_SHIFT,
    localparam int LW        = ADDR_W - UNIT_SHIFT,
    localparam int IDX_W     = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [LW-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ROWS-1:0]   row_sel_o,
    output logic              hit_o,
    output logic [ADDR_W-1:0] row_off_o
);
    logic [ROWS*LW-1:0] lim_flat;
    logic [ROWS*LW-1:0] base_flat;
    logic [ROWS-1:0]    live_s;

    rowbound_regs #(.ROWS(ROWS), .LW(LW), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .lim_o     (lim_flat)
    );

    rowbound_chain #(.ROWS(ROWS), .LW(LW)) u_chain (
        .lim_i  (lim_flat),
        .base_o (base_flat),
        .live_o (live_s)
    );

    rowbound_match #(
        .ROWS(ROWS), .LW(LW), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_match (
        .addr_i (addr_i),
        .lim_i  (lim_flat),
        .base_i (base_flat),
        .live_i (live_s),
        .sel_o  (row_sel_o),
        .hit_o  (hit_o),
        .off_o  (row_off_o)
    );
endmodule

// File: rtl/rowbound_decoder_chk.sv
module rowbound_decoder_chk #(
    parameter int ROWS       = 4,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 24,
    parameter int LW         = 8,
    parameter int IDX_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [IDX_W-1:0]  wr_idx_i,
    input logic [LW-1:0]     wr_data_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ROWS-1:0]   row_sel_o,
    input logic              hit_o,
    input logic [ADDR_W-1:0] row_off_o,
    input logic [ROWS*LW-1:0] lim_flat
);
    logic [LW-1:0] top_lim;

    always_comb begin
        top_lim = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (lim_flat[r*LW +: LW] > top_lim) top_lim = lim_flat[r*LW +: LW];
        end
    end

    // R1: a write lands in the addressed limit register
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (lim_flat[$past(wr_idx_i)*LW +: LW] == $past(wr_data_i)));

    // R2: limits are clear when reset is released
    assert_reset_clear_R2: assert property (@(posedge clk)
        $rose(rst_n) |-> (lim_flat == '0));

    // R6: never more than one row selected
    assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel_o));

    // R6: hit flag agrees with the select vector
    assert_hit_vs_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == (row_sel_o != '0));

    // R7: hit exactly when below the highest programmed limit
    assert_top_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == (addr_i[ADDR_W-1:UNIT_SHIFT] < top_lim));

    // R8: low address bits pass straight into the offset on a hit
    assert_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (row_off_o[UNIT_SHIFT-1:0] == addr_i[UNIT_SHIFT-1:0]));

    // R8: offset is zero on a miss
    assert_miss_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (row_off_o == '0));
endmodule

bind rowbound_decoder rowbound_decoder_chk #(
    .ROWS(ROWS), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT), .LW(LW), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .addr_i    (addr_i),
    .row_sel_o (row_sel_o),
    .hit_o     (hit_o),
    .row_off_o (row_off_o),
    .lim_flat  (lim_flat)
);

// File: tb/rowbound_decoder_test.sv
`timescale 1ns/1ps
module rowbound_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_idx_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [31:0] addr_i = '0;
    logic [3:0]  row_sel_o;
    logic        hit_o;
    logic [31:0] row_off_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rowbound_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_data_i(wr_data_i), .addr_i(addr_i), .row_sel_o(row_sel_o),
        .hit_o(hit_o), .row_off_o(row_off_o)
    );

    task automatic put_limit(input logic [1:0] idx, input logic [7:0] val);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = val;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic put_all(input logic [7:0] a, b, c, d);
        put_limit(2'd0, a); put_limit(2'd1, b);
        put_limit(2'd2, c); put_limit(2'd3, d);
    endtask

    task automatic expect_now(input logic [3:0] sel, input logic hit,
                              input logic [31:0] off, input string tag);
        checks++;
        if (row_sel_o !== sel || hit_o !== hit || row_off_o !== off) begin
            fails++;
            $display("FAIL %s addr=%h: got sel=%b hit=%b off=%h, expected sel=%b hit=%b off=%h",
                     tag, addr_i, row_sel_o, hit_o, row_off_o, sel, hit, off);
        end
    endtask

    task automatic look(input logic [31:0] a, input logic [3:0] sel, input logic hit,
                        input logic [31:0] off, input string tag);
        @(negedge clk);
        addr_i = a;
        #1;
        expect_now(sel, hit, off, tag);
    endtask

    task automatic t_reset;
        look(32'h0000_0000, 4'b0000, 1'b0, 32'h0, "R2 reset low");
        look(32'hFF00_0000, 4'b0000, 1'b0, 32'h0, "R2 reset high");
    endtask

    task automatic t_write_timing;
        @(negedge clk);
        addr_i = 32'h0100_0000;
        wr_en_i = 1'b1; wr_idx_i = 2'd0; wr_data_i = 8'd2;
        #1;
        expect_now(4'b0000, 1'b0, 32'h0, "R1 before edge");
        @(negedge clk);
        wr_en_i = 1'b0;
        #1;
        expect_now(4'b0001, 1'b1, 32'h0100_0000, "R1 after edge");
    endtask

    task automatic t_basic;
        put_all(8'd2, 8'd4, 8'd8, 8'd16);
        look(32'h0100_0000, 4'b0001, 1'b1, 32'h0100_0000, "R3 row0");
        look(32'h0200_0000, 4'b0010, 1'b1, 32'h0000_0000, "R4 row1 base");
        look(32'h05AB_CDEF, 4'b0100, 1'b1, 32'h01AB_CDEF, "R8 row2 offset");
        look(32'h0FFF_FFFF, 4'b1000, 1'b1, 32'h07FF_FFFF, "R3 row3 top");
        look(32'h1000_0000, 4'b0000, 1'b0, 32'h0, "R7 at top limit");
    endtask

    task automatic t_empty;
        put_all(8'd3, 8'd3, 8'd5, 8'd5);
        look(32'h0200_0000, 4'b0001, 1'b1, 32'h0200_0000, "R5 row0");
        look(32'h0300_0000, 4'b0100, 1'b1, 32'h0000_0000, "R5 skip empty row1");
        look(32'h04FF_FFFF, 4'b0100, 1'b1, 32'h01FF_FFFF, "R6 row2 end");
        look(32'h0500_0000, 4'b0000, 1'b0, 32'h0, "R5 empty row3 miss");
    endtask

    task automatic t_order;
        put_all(8'd6, 8'd2, 8'd9, 8'd20);
        look(32'h0100_0000, 4'b0001, 1'b1, 32'h0100_0000, "R5 low limit ignored");
        look(32'h0700_0000, 4'b0100, 1'b1, 32'h0100_0000, "R4 row2 base is max");
        look(32'h0A00_0000, 4'b1000, 1'b1, 32'h0100_0000, "R4 row3");
        look(32'h1400_0000, 4'b0000, 1'b0, 32'h0, "R7 above top");
    endtask

    task automatic t_mixed;
        put_all(8'd1, 8'd33, 8'd34, 8'd255);
        look(32'h00FF_FFFF, 4'b0001, 1'b1, 32'h00FF_FFFF, "R9 16MB row");
        look(32'h2000_0000, 4'b0010, 1'b1, 32'h1F00_0000, "R9 512MB row");
        look(32'h2100_0000, 4'b0100, 1'b1, 32'h0000_0000, "R9 one-unit row");
        look(32'hFEFF_FFFF, 4'b1000, 1'b1, 32'hDCFF_FFFF, "R9 large row");
        look(32'hFF00_0000, 4'b0000, 1'b0, 32'h0, "R7 top unit");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_timing();
        t_basic();
        t_empty();
        t_order();
        t_mixed();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule